// File: doc/BRIEF.md
# Two-Operand Destructive Integer ALU

This block is the integer execution unit of a small accumulator-style machine in which every operation overwrites its destination. It takes the destination register's current value and a second operand, and from them it forms the value that will be written back to the destination. An operation select picks one of eleven functions:

- wrapping add and subtract
- low-half multiply
- the four bitwise forms: AND, OR, XOR and bit-clear
- copy and negate of the second operand
- a signed less-than test that yields 0 or 1
- an arithmetic shift whose direction follows the sign of the second operand

The block is purely combinational. Its result and zero indicator are valid in the same cycle as its inputs. The surrounding pipeline registers the result, and when the instruction asks for the flag to be updated it also registers `is_zero`. No data is held inside the block, so it has no valid/ready handshake. The caller presents operands whenever it likes and reads the outputs once the inputs have settled.

Top module: `acc_alu16`

## Requirements
- R1: Select code 0 gives rd+op2 and code 1 gives rd-op2, both taken modulo 2^16 with no carry or overflow output.
- R2: Select code 2 gives the low 16 bits of the product rd*op2.
- R3: Select codes 3, 4, 5 and 6 give rd AND op2, rd OR op2, rd XOR op2 and rd AND NOT op2, in that order.
- R4: Select code 7 gives op2, and code 8 gives the two's-complement negation of op2. For both codes rd has no effect on the result.
- R5: Select code 9 gives 1 when rd < op2 compared as signed 16-bit integers, and 0 otherwise.
- R6: Select code 10 with op2 positive (signed) gives rd shifted left by op2 with zeros filled in. A left amount of 16 or more gives 0.
- R7: Select code 10 with op2 negative gives rd shifted right arithmetically by -op2. A right amount of 16 or more gives 16 copies of rd's sign bit.
- R8: Select code 10 with op2 equal to 0 returns rd unchanged.
- R9: `is_zero` is 1 exactly when the 16-bit result is 0, for every select code.
- R10: Select codes 11 to 15 are unassigned and give a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation select code |
| rd_val | input | 16 | Current destination register value |
| op2_val | input | 16 | Second operand (register or constant) |
| result | output | 16 | New destination value |
| is_zero | output | 1 | High when result is zero |

## Verification
Every select code is crossed with a fixed set of boundary words:

- 0 and ±1
- the most positive and most negative values
- alternating bit patterns
- values around ±16

These show up wrap-around in add and subtract, sign errors in the compare, and confusion between rd and op2. The shift is swept across every amount from -40 to +40 with several values of rd. This separates left from right, logical from arithmetic fill, and the zero-amount case, and it checks saturation on both sides of 16. A long pseudo-random run over all sixteen codes then exercises the multiplier's low half and the unassigned codes. On every vector the bench also checks the zero indicator against the expected result.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_MUL = 4'd2,
    OP_AND = 4'd3,
    OP_ORR = 4'd4,
    OP_EOR = 4'd5,
    OP_BIC = 4'd6,
    OP_MOV = 4'd7,
    OP_NEG = 4'd8,
    OP_SLT = 4'd9,
    OP_SHA = 4'd10
  } alu_op_e;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int W = 16
) (
  input  logic [W-1:0] rd,
  input  logic [W-1:0] op2,
  output logic [W-1:0] sum,
  output logic [W-1:0] diff,
  output logic [W-1:0] neg,
  output logic [W-1:0] prod,
  output logic [W-1:0] lt_word
);
  logic lt;

  // Wrapping arithmetic: results are truncated to W bits (R1, R2)
  always_comb begin
    sum  = rd + op2;
    diff = rd - op2;
    neg  = '0 - op2;
    prod = rd * op2;
  end

  // Signed compare gives a 0/1 word (R5)
  assign lt      = $signed(rd) < $signed(op2);
  assign lt_word = {{(W-1){1'b0}}, lt};
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 16
) (
  input  logic [W-1:0] rd,
  input  logic [W-1:0] op2,
  output logic [W-1:0] and_v,
  output logic [W-1:0] or_v,
  output logic [W-1:0] xor_v,
  output logic [W-1:0] bic_v
);
  // One bit slice per position (R3)
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign and_v[b] = rd[b] & op2[b];
    assign or_v[b]  = rd[b] | op2[b];
    assign xor_v[b] = rd[b] ^ op2[b];
    assign bic_v[b] = rd[b] & ~op2[b];
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W = 16
) (
  input  logic [W-1:0] rd,
  input  logic [W-1:0] amt,
  output logic [W-1:0] shv
);
  localparam int SW = $clog2(W);

  logic          go_right;
  logic [W-1:0]  mag;
  logic          too_far;
  logic          sgn;
  logic [W-1:0]  lstage [SW+1];
  logic [W-1:0]  rstage [SW+1];

  // The sign of amt picks the direction; the magnitude is the count (R6, R7)
  assign go_right = amt[W-1];
  assign mag      = go_right ? ('0 - amt) : amt;
  assign too_far  = |mag[W-1:SW];
  assign sgn      = rd[W-1];

  assign lstage[0] = rd;
  assign rstage[0] = rd;

  // Log-depth barrel stages, one per bit of the count
  for (genvar g = 0; g < SW; g++) begin : g_stage
    localparam int STEP = 2 ** g;
    assign lstage[g+1] = mag[g] ? {lstage[g][W-1-STEP:0], {STEP{1'b0}}} : lstage[g];
    assign rstage[g+1] = mag[g] ? {{STEP{sgn}}, rstage[g][W-1:STEP]} : rstage[g];
  end

  // A count of W or more saturates: 0 to the left, sign fill to the right
  always_comb begin
    if (go_right) shv = too_far ? {W{sgn}} : rstage[SW];
    else          shv = too_far ? '0       : lstage[SW];
  end
endmodule

// File: rtl/acc_alu16.sv
module acc_alu16 #(
  parameter int W = 16
) (
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] rd_val,
  input  logic [W-1:0] op2_val,
  output logic [W-1:0] result,
  output logic         is_zero
);
  import acc_alu_pkg::*;

  logic [W-1:0] sum_v, diff_v, neg_v, prod_v, lt_v;
  logic [W-1:0] and_v, or_v, xor_v, bic_v;
  logic [W-1:0] sh_v;

  alu_arith #(.W(W)) u_arith (
    .rd(rd_val), .op2(op2_val),
    .sum(sum_v), .diff(diff_v), .neg(neg_v), .prod(prod_v), .lt_word(lt_v)
  );

  alu_logic #(.W(W)) u_logic (
    .rd(rd_val), .op2(op2_val),
    .and_v(and_v), .or_v(or_v), .xor_v(xor_v), .bic_v(bic_v)
  );

  alu_shift #(.W(W)) u_shift (
    .rd(rd_val), .amt(op2_val), .shv(sh_v)
  );

  // Result select; unassigned codes give 0 (R10)
  always_comb begin
    unique case (alu_op_e'(op_sel))
      OP_ADD:  result = sum_v;
      OP_SUB:  result = diff_v;
      OP_MUL:  result = prod_v;
      OP_AND:  result = and_v;
      OP_ORR:  result = or_v;
      OP_EOR:  result = xor_v;
      OP_BIC:  result = bic_v;
      OP_MOV:  result = op2_val;
      OP_NEG:  result = neg_v;
      OP_SLT:  result = lt_v;
      OP_SHA:  result = sh_v;
      default: result = '0;
    endcase
  end

  // Zero indicator for the flag-setting path (R9)
  assign is_zero = (result == '0);

  // Cross-unit consistency checks
  always_comb begin
    a_r1_sub_undoes_add: assert (diff_v + op2_val == rd_val)
      else $error("R1: subtract path disagrees with operands");
    a_r3_xor_identity: assert (xor_v == (or_v & ~and_v))
      else $error("R3: xor differs from or-and-not-and");
    a_r3_bic_identity: assert (bic_v == (rd_val ^ and_v))
      else $error("R3: bit-clear differs from rd xor and");
    a_r4_neg_cancels: assert (neg_v + op2_val == '0)
      else $error("R4: negation does not cancel op2");
    a_r5_slt_boolean: assert (lt_v[W-1:1] == '0)
      else $error("R5: compare produced more than one bit");
    if (op2_val == '0) begin
      a_r8_zero_shift: assert (sh_v == rd_val)
        else $error("R8: zero shift changed rd");
    end
    if (op2_val[W-1]) begin
      a_r7_sign_kept: assert (sh_v[W-1] == rd_val[W-1])
        else $error("R7: right shift lost sign");
    end
  end
endmodule

// File: tb/acc_alu16_bench.sv
module acc_alu16_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [15:0] rd_val = '0;
  logic [15:0] op2_val = '0;
  logic [15:0] result;
  logic        is_zero;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  acc_alu16 #(.W(16)) u_acc_alu16 (
    .op_sel(op_sel), .rd_val(rd_val), .op2_val(op2_val),
    .result(result), .is_zero(is_zero)
  );

  function automatic string tag_of(int op, logic [15:0] b);
    case (op)
      0, 1:          return "R1";
      2:             return "R2";
      3, 4, 5, 6:    return "R3";
      7, 8:          return "R4";
      9:             return "R5";
      10: begin
        if ($signed(b) > 0)      return "R6";
        else if ($signed(b) < 0) return "R7";
        else                     return "R8";
      end
      default:       return "R10";
    endcase
  endfunction

  function automatic logic [15:0] model(int op, logic [15:0] a, logic [15:0] b);
    longint ua, ub, sa, sb, r, d, q, m;
    ua = a; ub = b;
    sa = $signed(a); sb = $signed(b);
    r = 0;
    case (op)
      0:  r = ua + ub;
      1:  r = ua - ub + 65536;
      2:  r = ua * ub;
      3:  r = a & b;
      4:  r = a | b;
      5:  r = a ^ b;
      6:  r = a & ~b;
      7:  r = ub;
      8:  r = 65536 - ub;
      9:  r = (sa < sb) ? 1 : 0;
      10: begin
        if (sb > 0) begin
          r = (sb >= 16) ? 0 : ua * (longint'(1) << sb);
        end else if (sb < 0) begin
          m = -sb;
          if (m >= 16) r = (sa < 0) ? 65535 : 0;
          else begin
            d = longint'(1) << m;
            q = sa / d;
            if ((sa % d != 0) && (sa < 0)) q = q - 1;
            r = q;
          end
        end else r = ua;
      end
      default: r = 0;
    endcase
    return r[15:0];
  endfunction

  task automatic run(int op, logic [15:0] a, logic [15:0] b);
    logic [15:0] exp_v;
    @(negedge clk);
    op_sel = op[3:0]; rd_val = a; op2_val = b;
    #1;
    exp_v = model(op, a, b);
    n_cmp++;
    if (result !== exp_v) begin
      n_bad++;
      $display("FAIL %s op=%0d rd=%h op2=%h actual=%h expected=%h",
               tag_of(op, b), op, a, b, result, exp_v);
    end
    n_cmp++;
    if (is_zero !== (exp_v == 16'h0)) begin
      n_bad++;
      $display("FAIL R9 op=%0d rd=%h op2=%h actual=%b expected=%b",
               op, a, b, is_zero, (exp_v == 16'h0));
    end
  endtask

  logic [15:0] corners [16] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                                16'h8000, 16'h5555, 16'hAAAA, 16'h0002,
                                16'hFFFE, 16'h000F, 16'h0010, 16'hFFF1,
                                16'hFFF0, 16'hFFEF, 16'h0011, 16'h1234};

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Quiet state: all-zero inputs give a zero sum (R1, R9)
    run(0, 16'h0, 16'h0);
    // Boundary words crossed with every select code
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          run(op, corners[i], corners[j]);
    // Shift amount sweep (R6, R7, R8)
    for (int i = 0; i < 16; i++)
      for (int s = -40; s <= 40; s++)
        run(10, corners[i], 16'(s));
    // R4: rd has no effect on copy/negate
    for (int i = 0; i < 16; i++) begin
      run(7, corners[i], 16'hBEEF);
      run(8, corners[i], 16'h0123);
    end
    // Pseudo-random run over all codes
    lfsr = 32'hACE1_2345;
    for (int k = 0; k < 6000; k++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      run(k % 16, lfsr[31:16], lfsr[15:0]);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule